// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block receives 8-bit pixel samples from an image sensor over a pixel clock, a frame-sync line and a data bus. It groups every four samples into a 32-bit word and writes the word into a 32-entry receive queue. When the queue holds enough words to fill one transfer burst, the block raises a DMA request. A DMA engine then drains the words through a single receive data register. The block also produces the master clock for the sensor from the system clock through a programmable divider, and it keeps the start-of-frame and overrun flags that drive the interrupt line.

Software configures the block through three registers: control at offset 0x00, status at offset 0x08 and receive data at offset 0x10. The sensor pins are oversampled in the system clock domain through two-flop synchronizers. Capture is governed by a three-state machine:
- `ST_OFF` means the interface is disabled.
- `ST_HUNT` means the block is enabled and waiting for the first start of frame.
- `ST_GRAB` means samples are being packed.

Its transitions are:
- OFF→HUNT when the enable bit is set.
- HUNT→GRAB on an active start-of-frame edge.
- HUNT→OFF and GRAB→OFF when enable is cleared.
- GRAB→GRAB on a further start-of-frame edge, which restarts packing and drops any partly built word.

Top module: `cam_capture`

## Requirements
- R1: After reset the control and status registers read 0, and sensor_mclk, dma_req and irq are low.
- R2: Four accepted samples form one queue word. Status bit 0 is 1 while the queue is not empty. A read of offset 0x10 returns the oldest word and removes it. A read of 0x10 while the queue is empty returns 0.
- R3: With control bit 7 clear, the first sample of a word lands in bits 7:0 and the fourth lands in bits 31:24.
- R4: With control bit 7 set, the first sample of a word lands in bits 31:24 and the fourth lands in bits 7:0.
- R5: Control bit 1 set samples the data on the rising pixel-clock edge. Bit 1 clear samples it on the falling edge.
- R6: Control bit 2 set inverts every data bit before packing.
- R7: The frame-sync line is active high when control bit 17 is set and active low when it is clear. Its active edge sets status bit 16, which is cleared by writing 1 to it. irq is high exactly while status bit 16 and control bit 16 are both 1.
- R8: Samples arriving before the first start of frame after enabling are discarded. A start of frame during capture discards any partly built word.
- R9: Control bits 20:19 hold a value T, and the burst size is 4·2^T words. dma_req and status bit 18 are high while the block is enabled and the queue holds at least that many words.
- R10: The queue holds 32 words. A word completed while the queue is full is dropped and sets status bit 24, which is cleared by writing 1 to it.
- R11: Writing 1 to control bit 5 empties the queue and drops a partly built word. The bit always reads 0.
- R12: While control bits 0 and 9 are both set, sensor_mclk is a square wave with period 2·(D+1) system clocks, where D is control bits 15:12. Otherwise sensor_mclk stays low.
- R13: Writing 0 to control disables capture. Afterwards samples and frame syncs have no effect and dma_req stays low. Control reads back only its defined bits (mask 0x001BF397).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops queue at 0x10) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pix_clk | input | 1 | Sensor pixel clock |
| pix_vsync | input | 1 | Sensor frame-sync line |
| pix_data | input | 8 | Sensor pixel data |
| sensor_mclk | output | 1 | Master clock to the sensor |
| dma_req | output | 1 | Burst-ready request to the DMA engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench changes the data between the sampling edge and the opposite edge. A block that samples on the wrong edge would therefore pack the complemented byte. Byte order is checked with four distinct samples in both packing modes, and a swapped lane shows up as a permuted word. The bench sends a partial word followed by a fresh start of frame, then clears the queue mid-word. A design that keeps stale samples would shift them into the next word.

The bench pushes 33 words into the 32-deep queue and then drains it in order. A design that overwrote an entry or missed the overrun flag would return a wrong sequence or a clear bit 24. It also checks that the burst request appears exactly at the programmed level and not one word earlier.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_GRAB = 2'd2
    } cap_state_e;

    // register offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_RXD  = 'h10;

    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_REDGE  = 1;
    localparam int B_DINV   = 2;
    localparam int B_CLR    = 5;
    localparam int B_BE     = 7;
    localparam int B_MCKE   = 9;
    localparam int B_DIV_LO = 12;
    localparam int B_SIEN   = 16;
    localparam int B_SPOL   = 17;
    localparam int B_THR_LO = 19;

    // status bit positions
    localparam int S_DRDY = 0;
    localparam int S_SOF  = 16;
    localparam int S_THR  = 18;
    localparam int S_OVR  = 24;

    localparam logic [31:0] CTRL_KEEP = 32'h001B_F397;
    localparam int          THR_BASE  = 4;

endpackage

// File: rtl/cam_pin_sync.sv
module cam_pin_sync #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_clk,
    input  logic             pix_vsync,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             rise_sel,
    input  logic             sof_hi,
    input  logic             inv,
    output logic             smp_stb,
    output logic [PIX_W-1:0] smp_byte,
    output logic             sof_stb
);
    logic [2:0]       pclk_sh;
    logic [1:0]       vs_sh;
    logic [PIX_W-1:0] d1_q, d2_q;
    logic             vs_act, vs_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_sh  <= '0;
            vs_sh    <= '0;
            d1_q     <= '0;
            d2_q     <= '0;
            vs_act_q <= 1'b0;
        end else begin
            pclk_sh  <= {pclk_sh[1:0], pix_clk};
            vs_sh    <= {vs_sh[0], pix_vsync};
            d1_q     <= pix_data;
            d2_q     <= d1_q;
            vs_act_q <= vs_act;
        end
    end

    always_comb begin
        vs_act   = vs_sh[1] ~^ sof_hi;
        smp_stb  = rise_sel ? (pclk_sh[1] & ~pclk_sh[2]) : (~pclk_sh[1] & pclk_sh[2]);
        smp_byte = d2_q ^ {PIX_W{inv}};
        sof_stb  = vs_act & ~vs_act_q;
    end
endmodule

// File: rtl/cam_packer.sv
module cam_packer
    import cam_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              big_end,
    input  logic              flush,
    input  logic              smp_stb,
    input  logic [PIX_W-1:0]  smp_byte,
    input  logic              sof_stb,
    output logic              word_push,
    output logic [WORD_W-1:0] word_data,
    output logic              sof_evt,
    output cap_state_e        state_o
);
    localparam int BPW   = WORD_W / PIX_W;
    localparam int CNT_W = $clog2(BPW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BPW - 1);

    cap_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q, acc_nxt;
    logic              take, restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (en) st_d = ST_HUNT;
            ST_HUNT: if (!en) st_d = ST_OFF;
                     else if (sof_stb) st_d = ST_GRAB;
            ST_GRAB: if (!en) st_d = ST_OFF;
            default: st_d = ST_OFF;
        endcase
    end

    always_comb begin
        restart   = !en || flush || sof_stb || (st_q != ST_GRAB);
        take      = smp_stb && !restart;
        acc_nxt   = big_end ? {acc_q[WORD_W-PIX_W-1:0], smp_byte}
                            : {smp_byte, acc_q[WORD_W-1:PIX_W]};
        word_push = take && (cnt_q == LAST);
        word_data = acc_nxt;
        sof_evt   = en && sof_stb && (st_q != ST_OFF);
        state_o   = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= acc_nxt;
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cam_rx_fifo.sv
module cam_rx_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic [$clog2(DEPTH):0] level,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [AW:0]       cnt_q;
    logic              do_push, do_pop;

    always_comb begin
        full    = (cnt_q == (AW+1)'(DEPTH));
        empty   = (cnt_q == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = mem[rp_q];
        level   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp_q] <= wdata;
    end
endmodule

// File: rtl/cam_mclk_gen.sv
module cam_mclk_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mclk
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mclk  <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            mclk  <= ~mclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 5,
    parameter int DIV_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pix_clk,
    input  logic              pix_vsync,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              sensor_mclk,
    output logic              dma_req,
    output logic              irq
);
    localparam int WORD_W = 32;
    localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

    logic [31:0]       ctrl_q, stat_word;
    logic              sof_pend_q, ovr_q;
    logic              cfg_en, mclk_run, thr_hit;
    logic              ctrl_wr, stat_wr, rx_sel, fifo_clr, fifo_pop;
    logic              smp_stb, sof_stb, sof_evt, word_push;
    logic [PIX_W-1:0]  smp_byte;
    logic [WORD_W-1:0] word_data, fifo_rdata;
    logic [LVL_W-1:0]  fifo_level, thr_lvl;
    logic              fifo_full, fifo_empty;
    cap_state_e        cap_state;

    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
        stat_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
        rx_sel   = (reg_addr == ADDR_W'(OFS_RXD));
        fifo_clr = ctrl_wr && reg_wdata[B_CLR];
        fifo_pop = reg_rd && rx_sel;
        cfg_en   = ctrl_q[B_EN];
        mclk_run = cfg_en && ctrl_q[B_MCKE];
        thr_lvl  = LVL_W'(THR_BASE) << ctrl_q[B_THR_LO +: 2];
        thr_hit  = cfg_en && (fifo_level >= thr_lvl);
        dma_req  = thr_hit;
        irq      = sof_pend_q && ctrl_q[B_SIEN];
    end

    cam_pin_sync #(.PIX_W(PIX_W)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pix_clk(pix_clk), .pix_vsync(pix_vsync), .pix_data(pix_data),
        .rise_sel(ctrl_q[B_REDGE]), .sof_hi(ctrl_q[B_SPOL]), .inv(ctrl_q[B_DINV]),
        .smp_stb(smp_stb), .smp_byte(smp_byte), .sof_stb(sof_stb)
    );

    cam_packer #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .big_end(ctrl_q[B_BE]),
        .flush(fifo_clr), .smp_stb(smp_stb), .smp_byte(smp_byte), .sof_stb(sof_stb),
        .word_push(word_push), .word_data(word_data), .sof_evt(sof_evt),
        .state_o(cap_state)
    );

    cam_rx_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(word_push), .wdata(word_data), .pop(fifo_pop), .rdata(fifo_rdata),
        .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
    );

    cam_mclk_gen #(.DIV_W(DIV_W)) u_mclk (
        .clk(clk), .rst_n(rst_n), .run(mclk_run),
        .div(ctrl_q[B_DIV_LO +: DIV_W]), .mclk(sensor_mclk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            sof_pend_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_KEEP;
            if (sof_evt)                           sof_pend_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_SOF])  sof_pend_q <= 1'b0;
            if (word_push && fifo_full)            ovr_q <= 1'b1;
            else if (stat_wr && reg_wdata[S_OVR])  ovr_q <= 1'b0;
        end
    end

    always_comb begin
        stat_word         = '0;
        stat_word[S_DRDY] = ~fifo_empty;
        stat_word[S_SOF]  = sof_pend_q;
        stat_word[S_THR]  = thr_hit;
        stat_word[S_OVR]  = ovr_q;
        if (reg_addr == ADDR_W'(OFS_CTRL))      reg_rdata = ctrl_q;
        else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = stat_word;
        else if (rx_sel)                        reg_rdata = fifo_empty ? '0 : fifo_rdata;
        else                                    reg_rdata = '0;
    end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk
    import cam_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_req,
    input logic             irq,
    input logic             sensor_mclk,
    input logic             cfg_en,
    input logic             mclk_run,
    input logic             sof_pend,
    input logic             word_push,
    input cap_state_e       cap_state,
    input logic [LVL_W-1:0] fifo_level
);
    // R10: queue occupancy never exceeds its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R9: burst request only when enabled and data is queued
    p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (cfg_en && fifo_level != '0));

    // R12: master clock falls silent one cycle after it is stopped
    p_mclk_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_run |=> !sensor_mclk);

    // R8: words are only produced while capturing a frame
    p_push_grab_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_push |-> (cap_state == ST_GRAB));

    // R7: interrupt needs a pending start-of-frame flag
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sof_pend);
endmodule

bind cam_capture cam_capture_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .irq(irq),
    .sensor_mclk(sensor_mclk), .cfg_en(cfg_en), .mclk_run(mclk_run),
    .sof_pend(sof_pend_q), .word_push(word_push), .cap_state(cap_state),
    .fifo_level(fifo_level)
);

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h08, A_RX = 5'h10;
    localparam logic [31:0] EN = 32'h1, RE = 32'h2, INV = 32'h4, CLR = 32'h20,
                            BE = 32'h80, MCKE = 32'h200, SIEN = 32'h1_0000,
                            SPOL = 32'h2_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic pix_clk = 1'b0, pix_vsync = 1'b1;
    logic [7:0] pix_data = '0;
    logic sensor_mclk, dma_req, irq;
    logic rise_mode = 1'b0, vs_lvl = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cam_capture dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_clk(pix_clk), .pix_vsync(pix_vsync), .pix_data(pix_data),
        .sensor_mclk(sensor_mclk), .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic cfg(input logic [31:0] w);
        wr(A_CTRL, 32'h0);
        rise_mode = w[1];
        vs_lvl    = w[17];
        pix_clk   = ~rise_mode;
        pix_vsync = ~vs_lvl;
        repeat (5) @(negedge clk);
        wr(A_CTRL, w | CLR);
        wr(A_STAT, 32'h0101_0000);
    endtask

    task automatic send_byte(input logic [7:0] b);
        pix_data = b;
        repeat (2) @(negedge clk);
        pix_clk = rise_mode;
        repeat (3) @(negedge clk);
        pix_data = ~b;
        repeat (2) @(negedge clk);
        pix_clk = ~rise_mode;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] bytes_in_order);
        for (int k = 3; k >= 0; k--) send_byte(bytes_in_order[k*8 +: 8]);
    endtask

    task automatic pulse_sof();
        pix_vsync = vs_lvl;
        repeat (4) @(negedge clk);
        pix_vsync = ~vs_lvl;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
        rd(A_STAT, v); check("R1 stat reset", v, 32'h0);
        check("R1 outputs reset", {29'd0, sensor_mclk, dma_req, irq}, 32'h0);
    endtask

    task automatic t_little();
        logic [31:0] v;
        cfg(EN | RE | SPOL);
        pulse_sof();
        send_word(32'h11223344);
        rd(A_STAT, v); check("R2 drdy set", {31'd0, v[0]}, 32'h1);
        rd(A_RX, v);   check("R3 little order", v, 32'h44332211);
        rd(A_STAT, v); check("R2 drdy clear", {31'd0, v[0]}, 32'h0);
        rd(A_RX, v);   check("R2 empty read", v, 32'h0);
    endtask

    task automatic t_big();
        logic [31:0] v;
        cfg(EN | RE | SPOL | BE);
        pulse_sof();
        send_word(32'h11223344);
        rd(A_RX, v); check("R4 big order", v, 32'h11223344);
    endtask

    task automatic t_edge_inv();
        logic [31:0] v;
        cfg(EN);
        pulse_sof();
        send_word(32'hA50FF03C);
        rd(A_RX, v); check("R5 falling edge", v, 32'h3CF00FA5);
        cfg(EN | INV | RE);
        pulse_sof();
        send_word(32'hA50FF03C);
        rd(A_RX, v); check("R6 inverted data", v, 32'hC30FF05A);
    endtask

    task automatic t_sof_irq();
        logic [31:0] v;
        cfg(EN | RE | SPOL | SIEN);
        check("R7 irq idle", {31'd0, irq}, 32'h0);
        pulse_sof();
        check("R7 irq raised", {31'd0, irq}, 32'h1);
        rd(A_STAT, v); check("R7 sof flag", {31'd0, v[16]}, 32'h1);
        wr(A_STAT, 32'h0001_0000);
        rd(A_STAT, v); check("R7 sof w1c", {31'd0, v[16]}, 32'h0);
        check("R7 irq cleared", {31'd0, irq}, 32'h0);
        cfg(EN | RE);
        pulse_sof();
        rd(A_STAT, v); check("R7 active-low sof", {31'd0, v[16]}, 32'h1);
        check("R7 irq masked", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_hunt();
        logic [31:0] v;
        cfg(EN | RE | SPOL);
        send_word(32'h55667788);
        rd(A_STAT, v); check("R8 no capture before sof", {31'd0, v[0]}, 32'h0);
        pulse_sof();
        send_byte(8'h01); send_byte(8'h02);
        pulse_sof();
        send_word(32'h0A0B0C0D);
        rd(A_RX, v); check("R8 restart word", v, 32'h0D0C0B0A);
        rd(A_STAT, v); check("R8 single word", {31'd0, v[0]}, 32'h0);
    endtask

    task automatic t_thresh();
        logic [31:0] v;
        cfg(EN | RE | SPOL | (32'd1 << 19));
        pulse_sof();
        for (int i = 0; i < 7; i++) send_word(32'h01020304 + i);
        check("R9 below burst", {31'd0, dma_req}, 32'h0);
        rd(A_STAT, v); check("R9 thr flag low", {31'd0, v[18]}, 32'h0);
        send_word(32'hCAFEF00D);
        check("R9 burst reached", {31'd0, dma_req}, 32'h1);
        rd(A_STAT, v); check("R9 thr flag high", {31'd0, v[18]}, 32'h1);
        rd(A_RX, v);
        check("R9 drop below", {31'd0, dma_req}, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        int bad;
        cfg(EN | RE | SPOL | (32'd3 << 19));
        pulse_sof();
        for (int i = 0; i < 33; i++)
            for (int k = 0; k < 4; k++) send_byte(8'(i*4 + k));
        check("R10 full burst", {31'd0, dma_req}, 32'h1);
        rd(A_STAT, v); check("R10 overrun flag", {31'd0, v[24]}, 32'h1);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            rd(A_RX, v);
            if (v !== {8'(i*4+3), 8'(i*4+2), 8'(i*4+1), 8'(i*4)}) bad++;
        end
        check("R10 order of 32 words", 32'(bad), 32'h0);
        rd(A_STAT, v); check("R10 drained", {31'd0, v[0]}, 32'h0);
        wr(A_STAT, 32'h0100_0000);
        rd(A_STAT, v); check("R10 overrun w1c", {31'd0, v[24]}, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        cfg(EN | RE | SPOL);
        pulse_sof();
        send_word(32'h99887766);
        send_byte(8'hEE); send_byte(8'hFF);
        wr(A_CTRL, EN | RE | SPOL | CLR);
        rd(A_CTRL, v); check("R11 clr reads 0", v, EN | RE | SPOL);
        rd(A_STAT, v); check("R11 queue empty", {31'd0, v[0]}, 32'h0);
        send_word(32'h21222324);
        rd(A_RX, v); check("R11 partial dropped", v, 32'h24232221);
    endtask

    task automatic t_mclk();
        int hi, lo;
        cfg(EN | MCKE | (32'd2 << 12));
        repeat (4) @(negedge clk);
        while (sensor_mclk !== 1'b1) @(negedge clk);
        hi = 0;
        while (sensor_mclk === 1'b1 && hi < 50) begin hi++; @(negedge clk); end
        lo = 0;
        while (sensor_mclk === 1'b0 && lo < 50) begin lo++; @(negedge clk); end
        check("R12 high time div2", 32'(hi), 32'd3);
        check("R12 low time div2", 32'(lo), 32'd3);
        wr(A_CTRL, EN);
        hi = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (sensor_mclk) hi++; end
        check("R12 mclk stopped", 32'(hi), 32'd0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R13 defined bits", v, 32'h001B_F397);
        cfg(EN | RE | SPOL | (32'd0 << 19));
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); check("R13 ctrl zero", v, 32'h0);
        pulse_sof();
        send_word(32'h12345678);
        rd(A_STAT, v); check("R13 nothing captured", v, 32'h0);
        check("R13 outputs quiet", {30'd0, dma_req, sensor_mclk}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_little();
        t_big();
        t_edge_inv();
        t_sof_irq();
        t_hunt();
        t_thresh();
        t_overrun();
        t_clear();
        t_mclk();
        t_disable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule